// File: doc/BRIEF.md
# Floppy Sector Frame Builder

This block prepares one raw 137-byte sector image for a hard-sectored floppy write path. A write operation starts with a one-cycle request. The request carries the target track, the sector number and a 16-bit load-address word. The block then takes in exactly 128 payload bytes through a valid/ready input and stores them. While the bytes arrive it keeps a running modulo-256 sum. It then emits the finished frame, one byte per accepted output handshake.

Two frame layouts exist. The boot tracks (0 to 5) carry the load-address word ahead of the payload, and the stop byte and sum after it. All other tracks carry the sector number and the sum ahead of the payload. The sum must therefore be known before the first payload byte leaves, which is why the whole payload is buffered before emission begins.

A head-current-reduce output tells the drive interface to lower write current on the inner tracks while an operation is in progress. A track number beyond the last track is refused with a one-cycle error pulse, and no frame is produced for it.

Top module: `sector_frame_builder`

## Requirements
- R1: After reset the block is idle: `busy`, `inReady`, `outValid`, `outLast`, `trackErr` and `headCurrentReduce` are all 0.
- R2: A `startValid` pulse while idle with `startTrack` <= 76 makes `busy` and `inReady` high from the next cycle on. The block then accepts exactly 128 bytes on `inValid && inReady`, and `outValid` stays 0 until all 128 have been accepted.
- R3: A `startValid` while `busy` is ignored. It raises no `trackErr`, and the frame in progress keeps the track, sector and address of the request that started it.
- R4: A request with `startTrack` > 76 produces a one-cycle `trackErr` pulse in the cycle after the request. `busy`, `inReady` and `outValid` stay 0.
- R5: Frame byte 0 is the track number plus 0x80, which is the 7-bit track with bit 7 set.
- R6: On tracks 0 to 5, frame byte 1 is bits 7:0 and byte 2 is bits 15:8 of the `loadAddr` value sampled with the request.
- R7: On tracks 0 to 5, bytes 3 to 130 are the payload in arrival order, byte 131 is 0xFF, byte 132 is the payload sum modulo 256, and bytes 133 to 136 are 0x00.
- R8: On tracks 6 to 76, byte 1 is the sector number, bytes 2, 3, 5 and 6 are 0x00, bytes 7 to 134 are the payload in arrival order, byte 135 is 0xFF and byte 136 is 0x00.
- R9: On tracks 6 to 76, byte 4 equals the modulo-256 sum of frame bytes 2 to 134 with byte 4 left out.
- R10: `headCurrentReduce` is 1 exactly while `busy` is 1 for a track from 43 to 76. It is 0 for tracks 0 to 42 and whenever the block is idle.
- R11: An output byte advances only on `outValid && outReady`. While stalled, `outData` holds its value. `outLast` marks byte 136, and `busy` falls in the cycle after that byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadAddr | input | 16 | Address word placed in boot-track frames, sampled with the request |
| startValid | input | 1 | One-cycle request to build a frame |
| startTrack | input | 7 | Target track number |
| startSector | input | 8 | Target sector number |
| inValid | input | 1 | Payload byte valid |
| inData | input | 8 | Payload byte |
| inReady | output | 1 | Block accepts payload bytes |
| outValid | output | 1 | Frame byte valid |
| outData | output | 8 | Frame byte |
| outReady | input | 1 | Consumer accepts frame byte |
| outLast | output | 1 | Current frame byte is the final one |
| busy | output | 1 | Operation in progress |
| trackErr | output | 1 | Pulse: request refused for an out-of-range track |
| headCurrentReduce | output | 1 | Lower write current for inner tracks |

## Verification
If the sequencer's byte counter slips, the port shows it within one transfer. The payload window shifts, and the fixed 0xFF/0x00 markers land at the wrong positions. `outLast` also comes at the wrong handshake, so busy is held or dropped early.

A stale or wrongly cleared sum shows up only at byte 132 (boot) or byte 4 (other tracks) of the next frame. An all-0xFF payload, whose sum wraps, checks the modulo behaviour.

A latched track or sector that a mid-operation request overwrote shows at byte 0 and in `headCurrentReduce` from the cycle after the stray request.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam int FRAME_LEN     = 137;
  localparam int PAY_LEN       = 128;
  localparam int CNT_W         = $clog2(FRAME_LEN);
  localparam int PAY_W         = $clog2(PAY_LEN);
  // boot-track layout positions
  localparam int BOOT_PAY_OFS  = 3;
  localparam int BOOT_STOP_POS = BOOT_PAY_OFS + PAY_LEN;
  localparam int BOOT_SUM_POS  = BOOT_STOP_POS + 1;
  // data-track layout positions
  localparam int DATA_SUM_POS  = 4;
  localparam int DATA_PAY_OFS  = 7;
  localparam int DATA_STOP_POS = DATA_PAY_OFS + PAY_LEN;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_EMIT} sfbState_t;

  typedef struct packed {
    logic             latchHdr;
    logic             storeByte;
    logic             emit;
    logic             active;
    logic [CNT_W-1:0] idx;
  } ctlStrobes_t;
endpackage

// File: rtl/sfb_control.sv
module sfb_control
  import sfb_pkg::*;
#(
  parameter int LAST_TRACK = 76
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic [6:0]  startTrack,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output logic        outLast,
  output logic        busy,
  output logic        trackErr,
  output ctlStrobes_t strobes
);
  sfbState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             trackOk;
  logic             reqIdle;

  always_comb begin
    trackOk  = int'(startTrack) <= LAST_TRACK;
    reqIdle  = (state == ST_IDLE) && startValid;
    inReady  = (state == ST_LOAD);
    outValid = (state == ST_EMIT);
    busy     = (state != ST_IDLE);
    outLast  = outValid && (cnt == CNT_W'(FRAME_LEN - 1));
    strobes.latchHdr  = reqIdle && trackOk;
    strobes.storeByte = inValid && inReady;
    strobes.emit      = outValid;
    strobes.active    = busy;
    strobes.idx       = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      trackErr <= 1'b0;
    end else begin
      trackErr <= reqIdle && !trackOk;
      case (state)
        ST_IDLE: begin
          if (reqIdle && trackOk) begin
            state <= ST_LOAD;
            cnt   <= '0;
          end
        end
        ST_LOAD: begin
          if (inValid) begin
            if (cnt == CNT_W'(PAY_LEN - 1)) begin
              state <= ST_EMIT;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_EMIT: begin
          if (outReady) begin
            if (cnt == CNT_W'(FRAME_LEN - 1)) begin
              state <= ST_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: no frame byte offered while payload is still loading
  p_no_out_in_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !outValid);

  // R2: load counter never reaches the payload length
  p_load_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (int'(cnt) < PAY_LEN));

  // R3: a request during load without a byte leaves the sequencer untouched
  p_busy_start_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && startValid && !inValid) |=> (inReady && $stable(cnt)));

  // R4: error pulse only ever seen while idle
  p_err_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    trackErr |-> !busy);

  // R11: a stalled output keeps its position
  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(cnt)));
endmodule

// File: rtl/sfb_datapath.sv
module sfb_datapath
  import sfb_pkg::*;
#(
  parameter int BOOT_LAST_TRACK = 5,
  parameter int HCR_FIRST_TRACK = 43
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic [6:0]  startTrack,
  input  logic [7:0]  startSector,
  input  logic [15:0] loadAddr,
  input  logic [7:0]  inData,
  output logic [7:0]  outData,
  output logic        headCurrentReduce
);
  logic [6:0]  trk;
  logic [7:0]  sec;
  logic [15:0] addr;
  logic [7:0]  sum;
  logic [7:0]  payMem [PAY_LEN];
  logic        bootFmt;
  logic [PAY_W-1:0] rdSel;
  logic [7:0]  payByte;
  int          pos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trk  <= '0;
      sec  <= '0;
      addr <= '0;
      sum  <= '0;
    end else if (strobes.latchHdr) begin
      trk  <= startTrack;
      sec  <= startSector;
      addr <= loadAddr;
      sum  <= '0;
    end else if (strobes.storeByte) begin
      sum  <= sum + inData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.storeByte) payMem[strobes.idx[PAY_W-1:0]] <= inData;
  end

  always_comb begin
    bootFmt = int'(trk) <= BOOT_LAST_TRACK;
    pos     = int'(strobes.idx);
    rdSel   = bootFmt ? PAY_W'(strobes.idx - CNT_W'(BOOT_PAY_OFS))
                      : PAY_W'(strobes.idx - CNT_W'(DATA_PAY_OFS));
    payByte = payMem[rdSel];
    headCurrentReduce = strobes.active && (int'(trk) >= HCR_FIRST_TRACK);
  end

  always_comb begin
    outData = 8'h00;
    if (pos == 0) begin
      outData = {1'b1, trk};
    end else if (bootFmt) begin
      if (pos == 1)                       outData = addr[7:0];
      else if (pos == 2)                  outData = addr[15:8];
      else if (pos < BOOT_STOP_POS)       outData = payByte;
      else if (pos == BOOT_STOP_POS)      outData = 8'hFF;
      else if (pos == BOOT_SUM_POS)       outData = sum;
    end else begin
      if (pos == 1)                       outData = sec;
      else if (pos == DATA_SUM_POS)       outData = sum;
      else if (pos >= DATA_PAY_OFS && pos < DATA_STOP_POS) outData = payByte;
      else if (pos == DATA_STOP_POS)      outData = 8'hFF;
    end
  end

  // R5: the leading byte of every frame carries the set marker bit
  p_hdr_msb_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emit && strobes.idx == '0) |-> outData[7]);

  // R3: latched header does not move while an operation is active
  p_hdr_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.active |=> (!strobes.active || ($stable(trk) && $stable(sec))));

  // R9: the sum is frozen once emission has begun
  p_sum_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emit && !strobes.latchHdr) |=> (!strobes.emit || $stable(sum)));
endmodule

// File: rtl/sector_frame_builder.sv
module sector_frame_builder
  import sfb_pkg::*;
#(
  parameter int LAST_TRACK      = 76,
  parameter int BOOT_LAST_TRACK = 5,
  parameter int HCR_FIRST_TRACK = 43
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] loadAddr,
  input  logic        startValid,
  input  logic [6:0]  startTrack,
  input  logic [7:0]  startSector,
  input  logic        inValid,
  input  logic [7:0]  inData,
  output logic        inReady,
  output logic        outValid,
  output logic [7:0]  outData,
  input  logic        outReady,
  output logic        outLast,
  output logic        busy,
  output logic        trackErr,
  output logic        headCurrentReduce
);
  ctlStrobes_t strobes;

  sfb_control #(.LAST_TRACK(LAST_TRACK)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .startTrack (startTrack),
    .inValid    (inValid),
    .inReady    (inReady),
    .outValid   (outValid),
    .outReady   (outReady),
    .outLast    (outLast),
    .busy       (busy),
    .trackErr   (trackErr),
    .strobes    (strobes)
  );

  sfb_datapath #(
    .BOOT_LAST_TRACK (BOOT_LAST_TRACK),
    .HCR_FIRST_TRACK (HCR_FIRST_TRACK)
  ) u_dp (
    .clk               (clk),
    .rstN              (rstN),
    .strobes           (strobes),
    .startTrack        (startTrack),
    .startSector       (startSector),
    .loadAddr          (loadAddr),
    .inData            (inData),
    .outData           (outData),
    .headCurrentReduce (headCurrentReduce)
  );

  // R11: stalled output byte holds its value
  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));

  // R10: reduced current only during an operation
  p_hcr_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    headCurrentReduce |-> busy);

  // R11: busy drops right after the final byte is taken
  p_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    (outLast && outReady) |=> !busy);
endmodule

// File: tb/tb_sector_frame_builder.sv
module tb_sector_frame_builder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] loadAddr = 16'h0100;
  logic        startValid = 1'b0;
  logic [6:0]  startTrack = '0;
  logic [7:0]  startSector = '0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inReady, outValid, outLast, busy, trackErr, headCurrentReduce;
  logic [7:0]  outData;
  logic        outReady = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] pay [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_frame_builder dut (
    .clk(clk), .rstN(rstN), .loadAddr(loadAddr), .startValid(startValid),
    .startTrack(startTrack), .startSector(startSector), .inValid(inValid),
    .inData(inData), .inReady(inReady), .outValid(outValid), .outData(outData),
    .outReady(outReady), .outLast(outLast), .busy(busy), .trackErr(trackErr),
    .headCurrentReduce(headCurrentReduce)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] paySum();
    logic [7:0] s = 8'h00;
    for (int k = 0; k < 128; k++) s = s + pay[k];
    return s;
  endfunction

  // reference frame model, built from the requirements
  function automatic logic [7:0] refByte(input int trk, input int sec, input int addr, input int i);
    if (i == 0) return 8'(trk + 8'h80);
    if (trk <= 5) begin
      if (i == 1) return 8'(addr);
      if (i == 2) return 8'(addr >> 8);
      if (i >= 3 && i <= 130) return pay[i-3];
      if (i == 131) return 8'hFF;
      if (i == 132) return paySum();
      return 8'h00;
    end
    if (i == 1) return 8'(sec);
    if (i >= 7 && i <= 134) return pay[i-7];
    if (i == 135) return 8'hFF;
    if (i == 4) begin
      logic [7:0] s = 8'h00;
      for (int j = 2; j <= 134; j++) if (j != 4) s = s + refByte(trk, sec, addr, j);
      return s;
    end
    return 8'h00;
  endfunction

  function automatic string reqOf(input int trk, input int i);
    if (i == 0) return "R5";
    if (trk <= 5) return (i <= 2) ? "R6" : "R7";
    return (i == 4) ? "R9" : "R8";
  endfunction

  task automatic sendStart(input int trk, input int sec, input int addr);
    @(negedge clk);
    startValid = 1'b1; startTrack = 7'(trk); startSector = 8'(sec); loadAddr = 16'(addr);
    @(negedge clk);
    startValid = 1'b0;
  endtask

  // streams payload; optionally fires a stray request in the middle (R3)
  task automatic loadPayload(input bit stray);
    int k = 0;
    while (k < 128) begin
      @(negedge clk);
      check("R2", "outValid during load", int'(outValid), 0);
      inValid = ($urandom_range(0, 3) != 0);
      inData = pay[k];
      if (stray && k == 40) begin
        startValid = 1'b1; startTrack = 7'd77; startSector = 8'h5A; loadAddr = 16'hBEEF;
      end else begin
        startValid = 1'b0;
      end
      if (inValid && inReady) begin
        @(posedge clk);
        k++;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    startValid = 1'b0;
  endtask

  task automatic collectFrame(input int trk, input int sec, input int addr, input bit stall);
    int i = 0;
    bit heldPrev = 1'b0;
    logic [7:0] prevData = 8'h00;
    while (i < 137) begin
      @(negedge clk);
      if (heldPrev) check("R11", "stalled byte held", int'(outData), int'(prevData));
      outReady = stall ? ($urandom_range(0, 1) == 1) : 1'b1;
      if (outValid && outReady) begin
        check(reqOf(trk, i), $sformatf("track %0d byte %0d", trk, i),
              int'(outData), int'(refByte(trk, sec, addr, i)));
        check("R11", "outLast position", int'(outLast), (i == 136) ? 1 : 0);
        check("R10", "head current flag", int'(headCurrentReduce), (trk >= 43) ? 1 : 0);
        i++;
        heldPrev = 1'b0;
      end else begin
        heldPrev = outValid;
        prevData = outData;
      end
    end
    @(negedge clk);
    outReady = 1'b0;
    check("R11", "busy after last byte", int'(busy), 0);
    check("R10", "head current idle", int'(headCurrentReduce), 0);
  endtask

  task automatic runFrame(input int trk, input int sec, input int addr, input int fill,
                          input bit stall, input bit stray);
    for (int k = 0; k < 128; k++) pay[k] = (fill < 0) ? 8'($urandom) : 8'(fill);
    sendStart(trk, sec, addr);
    check("R2", "busy after start", int'(busy), 1);
    check("R2", "inReady after start", int'(inReady), 1);
    check("R10", "head current at start", int'(headCurrentReduce), (trk >= 43) ? 1 : 0);
    loadPayload(stray);
    if (stray) check("R3", "no error from stray request", int'(trackErr), 0);
    collectFrame(trk, sec, addr, stall);
  endtask

  task automatic testReset();
    check("R1", "busy", int'(busy), 0);
    check("R1", "inReady", int'(inReady), 0);
    check("R1", "outValid", int'(outValid), 0);
    check("R1", "outLast", int'(outLast), 0);
    check("R1", "trackErr", int'(trackErr), 0);
    check("R1", "headCurrentReduce", int'(headCurrentReduce), 0);
  endtask

  task automatic testBadTrack(input int trk);
    @(negedge clk);
    startValid = 1'b1; startTrack = 7'(trk);
    @(negedge clk);
    startValid = 1'b0;
    check("R4", "trackErr pulse", int'(trackErr), 1);
    check("R4", "busy stays low", int'(busy), 0);
    @(negedge clk);
    check("R4", "trackErr one cycle", int'(trackErr), 0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R4", "no frame", int'(outValid | inReady | busy), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runFrame(0, 0, 16'h0100, -1, 1'b0, 1'b0);   // boot track, R6 R7
    runFrame(5, 3, 16'hA55A, 8'hFF, 1'b1, 1'b0); // boot track, sum wrap
    runFrame(6, 17, 16'h0100, -1, 1'b1, 1'b0);  // first data track, R8 R9
    runFrame(42, 31, 16'h0100, 8'hFF, 1'b0, 1'b0); // last full-current track
    runFrame(43, 1, 16'h0100, -1, 1'b1, 1'b0);  // first reduced-current track, R10
    runFrame(76, 31, 16'h0100, -1, 1'b1, 1'b1); // last track plus stray request, R3
    runFrame(2, 9, 16'h1234, -1, 1'b0, 1'b1);   // boot track with stray request, R3
    testBadTrack(77);
    testBadTrack(127);
    runFrame(20, 200, 16'h0100, 8'h00, 1'b1, 1'b0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule